// File: doc/BRIEF.md
# Multi-Mode PWM Timer Counter

This block is an up/down counter that advances on a count-enable tick (normally the output of a prescaler) and produces one PWM waveform plus three event strobes. A 4-bit waveform mode input picks the counting sequence and the source of the TOP limit. The sequence is one of: free-running, clear-on-compare, single-slope fast PWM, dual-slope phase-correct PWM, or phase-and-frequency-correct PWM. TOP is a fixed 8-, 9- or 10-bit limit, the compare A input, or the capture input.

In the PWM modes the compare value is double-buffered. The shadow copy reloads at a point that depends on the mode, so a new duty value written during a period never cuts a pulse short. The strobes are combinational and qualified by the tick. A system that contains the block uses them to raise interrupts or to chain other timers. The count and the PWM output are registered.

Top module: `wave_timer`

## Requirements
- R1: During reset, count is 0, pwm_o is 0, and with tick low all three strobes are 0.
- R2: The count and the direction change only on a clock edge where tick is high. With tick low the count holds.
- R3: Mode 0x0 and the reserved code 0xD count up by one per tick, with TOP = 0xFFFF, wrapping from 0xFFFF to 0.
- R4: Clear-on-compare counts up by one per tick and returns to 0 on the tick after count equals TOP. Mode 0x4 takes TOP from cmp_a directly. Mode 0xC takes TOP from cap_val.
- R5: Fast PWM with a fixed TOP counts 0..TOP and then returns to 0. The TOP values are 0x00FF for mode 0x5, 0x01FF for 0x6 and 0x03FF for 0x7.
- R6: Fast PWM mode 0xE takes TOP from cap_val. Mode 0xF takes TOP from the buffered compare value.
- R7: The dual-slope modes count 0 up to TOP, then down to 0, and each end value appears for exactly one tick. The phase-correct modes take TOP as follows: 0x1 uses 0x00FF, 0x2 uses 0x01FF, 0x3 uses 0x03FF, 0xA uses cap_val and 0xB uses the buffered compare value. The phase-and-frequency-correct modes take TOP as follows: 0x8 uses cap_val and 0x9 uses the buffered compare value.
- R8: The three strobes are combinational and qualified by tick. top_o = tick and count == TOP. bottom_o = tick and count == 0. match_o = tick and count == the active compare value.
- R9: The active compare value depends on the mode:
  - In modes 0x0, 0x4, 0xC and 0xD it is cmp_a. The shadow register copies cmp_a on every clock.
  - In fast PWM and phase-and-frequency-correct modes the shadow loads cmp_a on a tick at bottom.
  - In phase-correct modes the shadow loads cmp_a on a tick at TOP.
  - Outside these load points the shadow holds.
- R10: In fast PWM, pwm_o goes to 0 one clock after a tick with a match. On a tick at bottom without a match, pwm_o goes to 1 one clock later. A match takes priority over bottom.
- R11: In dual-slope modes, a tick with a match clears pwm_o while the counter is counting up and sets it while counting down, one clock later. The direction at the lower end is down.
- R12: In modes 0x0, 0x4, 0xC and 0xD, pwm_o is 0 from the next clock on. The direction register is also forced to up-counting in these modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| mode | input | 4 | Waveform mode code |
| cmp_a | input | CW | Compare A value (unbuffered input) |
| cap_val | input | CW | Capture register value, used as TOP in some modes |
| count | output | CW | Current counter value |
| match_o | output | 1 | Compare-match strobe |
| top_o | output | 1 | TOP strobe |
| bottom_o | output | 1 | BOTTOM strobe |
| pwm_o | output | 1 | PWM waveform output |

## Verification
The bench builds the block with its default counter width of 16 bits. With that width, a full free-running wrap from 0xFFFF back to 0 takes 65,536 ticks, which is affordable. The 8-, 9- and 10-bit fixed limits also complete whole periods, in both the single-slope and the dual-slope form. The register-sourced limits are kept to a few dozen counts. This leaves room to change the compare value in the middle of a period, and to test a compare value of zero and one above TOP, both of which pin the output. A gated tick pattern exercises holding between ticks.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [2:0] {
    K_NORM = 3'd0,
    K_CTC  = 3'd1,
    K_FAST = 3'd2,
    K_PC   = 3'd3,
    K_PFC  = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    T_MAX = 3'd0,
    T_8   = 3'd1,
    T_9   = 3'd2,
    T_10  = 3'd3,
    T_A   = 3'd4,
    T_CAP = 3'd5
  } tsrc_e;

  typedef struct packed {
    kind_e kind;
    tsrc_e tsrc;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [3:0] m);
    mode_cfg_t c;
    case (m)
      4'h1:    c = '{K_PC,   T_8};
      4'h2:    c = '{K_PC,   T_9};
      4'h3:    c = '{K_PC,   T_10};
      4'h4:    c = '{K_CTC,  T_A};
      4'h5:    c = '{K_FAST, T_8};
      4'h6:    c = '{K_FAST, T_9};
      4'h7:    c = '{K_FAST, T_10};
      4'h8:    c = '{K_PFC,  T_CAP};
      4'h9:    c = '{K_PFC,  T_A};
      4'hA:    c = '{K_PC,   T_CAP};
      4'hB:    c = '{K_PC,   T_A};
      4'hC:    c = '{K_CTC,  T_CAP};
      4'hE:    c = '{K_FAST, T_CAP};
      4'hF:    c = '{K_FAST, T_A};
      default: c = '{K_NORM, T_MAX};
    endcase
    return c;
  endfunction

  function automatic logic is_pwm(input kind_e k);
    return (k == K_FAST) || (k == K_PC) || (k == K_PFC);
  endfunction

  function automatic logic is_dual(input kind_e k);
    return (k == K_PC) || (k == K_PFC);
  endfunction
endpackage

// File: rtl/wt_cmp_buf.sv
module wt_cmp_buf
  import wt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  kind_e         kind,
  input  logic          top_hit,
  input  logic          bot_hit,
  input  logic [CW-1:0] cmp_in,
  output logic [CW-1:0] cmp_eff
);
  logic [CW-1:0] shadow_q;
  logic          load_now;

  always_comb begin
    case (kind)
      K_FAST, K_PFC: load_now = tick && bot_hit;
      K_PC:          load_now = tick && top_hit;
      default:       load_now = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        shadow_q <= '0;
    else if (load_now) shadow_q <= cmp_in;
  end

  assign cmp_eff = is_pwm(kind) ? shadow_q : cmp_in;

  // R9: without a tick a PWM-mode shadow cannot move
  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pwm(kind) && !tick) |=> $stable(shadow_q));
endmodule

// File: rtl/wt_counter.sv
module wt_counter
  import wt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  kind_e         kind,
  input  logic [CW-1:0] top_val,
  output logic [CW-1:0] cnt_o,
  output logic          up_o,
  output logic          top_hit,
  output logic          bot_hit
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] ALL1 = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          up_q, up_d;

  assign top_hit = (cnt_q == top_val);
  assign bot_hit = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (!is_dual(kind)) up_d = 1'b1;
    if (tick) begin
      case (kind)
        K_NORM: cnt_d = cnt_q + ONE;
        K_CTC, K_FAST: cnt_d = top_hit ? '0 : cnt_q + ONE;
        default: begin
          if (up_q) begin
            if (cnt_q >= top_val) begin
              up_d  = 1'b0;
              cnt_d = bot_hit ? '0 : cnt_q - ONE;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else if (bot_hit) begin
            up_d  = 1'b1;
            cnt_d = cnt_q + ONE;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;

  // R2: no tick, no movement
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R3: free-running wrap
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_NORM && tick && cnt_q == ALL1) |=> (cnt_q == '0));
  // R7: turn at TOP steps one below it
  a_r7_turn_top: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dual(kind) && tick && up_q && top_hit && top_val != '0)
      |=> (cnt_q == $past(cnt_q) - ONE) && !up_q);
  // R7: turn at zero steps to one and counts up
  a_r7_turn_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dual(kind) && tick && !up_q && bot_hit) |=> (cnt_q == ONE) && up_q);
endmodule

// File: rtl/wt_wave.sv
module wt_wave
  import wt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  kind_e kind,
  input  logic  up,
  input  logic  match,
  input  logic  bot_hit,
  output logic  pwm_o
);
  logic pwm_q, pwm_d;

  always_comb begin
    pwm_d = pwm_q;
    if (!is_pwm(kind)) begin
      pwm_d = 1'b0;
    end else if (tick) begin
      if (kind == K_FAST) begin
        if (match)        pwm_d = 1'b0;
        else if (bot_hit) pwm_d = 1'b1;
      end else if (match) begin
        pwm_d = !up;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;

  // R10: fast PWM clear on match, set at bottom otherwise
  a_r10_fast_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_FAST && tick && match) |=> !pwm_o);
  a_r10_fast_set: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_FAST && tick && bot_hit && !match) |=> pwm_o);
  // R11: dual-slope direction-dependent match action
  a_r11_up_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dual(kind) && tick && match && up) |=> !pwm_o);
  a_r11_down_set: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dual(kind) && tick && match && !up) |=> pwm_o);
  // R12: non-PWM modes drive the output low
  a_r12_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !is_pwm(kind) |=> !pwm_o);
endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [3:0]    mode,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cap_val,
  output logic [CW-1:0] count,
  output logic          match_o,
  output logic          top_o,
  output logic          bottom_o,
  output logic          pwm_o
);
  localparam logic [CW-1:0] TOP8  = CW'((1 << 8) - 1);
  localparam logic [CW-1:0] TOP9  = CW'((1 << 9) - 1);
  localparam logic [CW-1:0] TOP10 = CW'((1 << 10) - 1);

  mode_cfg_t     cfg;
  logic [CW-1:0] top_val, cmp_eff, cnt;
  logic          up, top_hit, bot_hit, match_hit;

  assign cfg = decode_mode(mode);

  always_comb begin
    case (cfg.tsrc)
      T_8:     top_val = TOP8;
      T_9:     top_val = TOP9;
      T_10:    top_val = TOP10;
      T_A:     top_val = cmp_eff;
      T_CAP:   top_val = cap_val;
      default: top_val = '1;
    endcase
  end

  wt_cmp_buf #(.CW(CW)) u_buf (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kind(cfg.kind),
    .top_hit(top_hit), .bot_hit(bot_hit), .cmp_in(cmp_a), .cmp_eff(cmp_eff)
  );

  wt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kind(cfg.kind), .top_val(top_val),
    .cnt_o(cnt), .up_o(up), .top_hit(top_hit), .bot_hit(bot_hit)
  );

  assign match_hit = (cnt == cmp_eff);

  wt_wave u_wave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kind(cfg.kind), .up(up),
    .match(match_hit), .bot_hit(bot_hit), .pwm_o(pwm_o)
  );

  assign count    = cnt;
  assign match_o  = tick && match_hit;
  assign top_o    = tick && top_hit;
  assign bottom_o = tick && bot_hit;

  // R8: strobes never fire without a tick
  a_r8_strobe_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !(match_o || top_o || bottom_o));
  // R5: fast PWM with fixed 8-bit top leaves 0xFF for zero
  a_r5_fast8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'h5 && tick && count == TOP8) |=> (count == '0));
endmodule

// File: tb/sim_wave_timer.sv
`timescale 1ns/1ps
module sim_wave_timer;
  typedef struct {
    int    cnt;
    bit    mt, tp, bt, pw;
    string rc, rs, rp;
  } item_t;

  logic        clk = 0, rst_n = 0, tick = 0;
  logic [3:0]  mode = 0;
  logic [15:0] cmp_a = 0, cap_val = 0;
  wire  [15:0] count;
  wire         match_o, top_o, bottom_o, pwm_o;

  int checks = 0, failures = 0;
  item_t sb[$];
  event  ev;
  string sec_s = "R8";

  int m_cnt, m_ocr;
  bit m_up, m_pwm;

  always #2.5 clk = ~clk;

  wave_timer u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
    .cmp_a(cmp_a), .cap_val(cap_val), .count(count), .match_o(match_o),
    .top_o(top_o), .bottom_o(bottom_o), .pwm_o(pwm_o));

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  // 0 norm, 1 ctc, 2 fast, 3 phase-correct, 4 phase-and-frequency-correct
  function automatic int kind_of(int md);
    if (md inside {1, 2, 3, 10, 11}) return 3;
    if (md inside {8, 9}) return 4;
    if (md inside {5, 6, 7, 14, 15}) return 2;
    if (md inside {4, 12}) return 1;
    return 0;
  endfunction

  function automatic int top_of(int md, int eff, int cap);
    if (md inside {1, 5}) return 255;
    if (md inside {2, 6}) return 511;
    if (md inside {3, 7}) return 1023;
    if (md inside {4, 9, 11, 15}) return eff;
    if (md inside {8, 10, 12, 14}) return cap;
    return 65535;
  endfunction

  function automatic string cnt_tag(int k, int md);
    if (k == 0) return "R3";
    if (k == 1) return "R4";
    if (k == 2) return (md >= 14) ? "R6" : "R5";
    return "R7";
  endfunction

  task automatic step(bit t);
    item_t it;
    int k, eff, tp, nc;
    bit mt, tph, bth, nu;
    tick = t;
    #1;
    k   = kind_of(mode);
    eff = (k >= 2) ? m_ocr : int'(cmp_a);
    tp  = top_of(mode, eff, cap_val);
    mt  = (m_cnt == eff);
    tph = (m_cnt == tp);
    bth = (m_cnt == 0);
    it.cnt = m_cnt; it.mt = t && mt; it.tp = t && tph; it.bt = t && bth;
    it.pw = m_pwm;
    it.rc = t ? cnt_tag(k, mode) : "R2";
    it.rs = sec_s;
    it.rp = (k == 2) ? "R10" : (k >= 3) ? "R11" : "R12";
    sb.push_back(it);
    ->ev;
    // next model state
    if (k < 2) m_ocr = cmp_a;
    else if (t && (((k == 2 || k == 4) && bth) || (k == 3 && tph))) m_ocr = cmp_a;
    if (k < 2) m_pwm = 0;
    else if (t && k == 2) begin
      if (mt) m_pwm = 0; else if (bth) m_pwm = 1;
    end else if (t && mt) m_pwm = !m_up;
    nc = m_cnt; nu = (k >= 3) ? m_up : 1;
    if (t) begin
      if (k == 0) nc = (m_cnt + 1) % 65536;
      else if (k <= 2) nc = tph ? 0 : (m_cnt + 1) % 65536;
      else if (m_up) begin
        if (m_cnt >= tp) begin nu = 0; nc = bth ? 0 : m_cnt - 1; end
        else nc = m_cnt + 1;
      end else if (bth) begin nu = 1; nc = 1; end
      else nc = m_cnt - 1;
    end
    m_cnt = nc; m_up = nu;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(int n, bit gated = 0);
    for (int i = 0; i < n; i++) step(gated ? ((i % 3) != 1) : 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tick = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", count, 0); chk("R1", pwm_o, 0);
    chk("R1", match_o, 0); chk("R1", top_o, 0); chk("R1", bottom_o, 0);
    @(negedge clk);
    rst_n = 1;
    m_cnt = 0; m_ocr = 0; m_up = 1; m_pwm = 0;
  endtask

  // scoreboard monitor
  initial begin
    item_t e;
    forever begin
      @(ev);
      e = sb.pop_front();
      chk(e.rc, count, e.cnt);
      chk(e.rs, match_o, e.mt);
      chk("R8", top_o, e.tp);
      chk("R8", bottom_o, e.bt);
      chk(e.rp, pwm_o, e.pw);
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R3 full wrap in free-running mode
    mode = 4'h0; cmp_a = 16'h1234; run(65540);
    mode = 4'hD; run(60);
    // R2 gated ticks in fast 8-bit mode, R10 waveform
    do_reset(); mode = 4'h5; cmp_a = 16'h40; run(900, 1);
    // R5 fixed tops with R9 mid-period duty change
    do_reset(); sec_s = "R9"; mode = 4'h6; cmp_a = 16'h100; run(700);
    cmp_a = 16'h20; run(700);
    mode = 4'h7; cmp_a = 16'h300; run(2100);
    // R4 clear-on-compare, direct and capture tops
    do_reset(); mode = 4'h4; cmp_a = 20; run(50); cmp_a = 10; run(40);
    mode = 4'hC; cap_val = 33; run(120);
    // R6 fast PWM register tops, edge duties
    do_reset(); mode = 4'hE; cap_val = 50; cmp_a = 20; run(160);
    cmp_a = 0; run(160); cmp_a = 60; run(160);
    mode = 4'hF; cmp_a = 30; run(100);
    // R7/R11 dual slope, fixed and register tops
    do_reset(); mode = 4'h1; cmp_a = 16'h30; run(600);
    do_reset(); mode = 4'h2; cmp_a = 16'h1F0; run(1100);
    do_reset(); mode = 4'h3; cmp_a = 16'h200; run(2100);
    do_reset(); mode = 4'h8; cap_val = 40; cmp_a = 15; run(100);
    cmp_a = 5; run(200);
    do_reset(); mode = 4'h9; cmp_a = 25; run(160);
    do_reset(); mode = 4'hA; cap_val = 30; cmp_a = 10; run(100);
    cmp_a = 0; run(130);
    do_reset(); mode = 4'hB; cmp_a = 20; run(60); cmp_a = 12; run(120, 1);
    // R12 back to a non-PWM mode clears the output
    mode = 4'h4; cmp_a = 50; run(40);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule